// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a simple host request port and an external, fully static SRAM array. The array has four 8-bit byte lanes and is 512K words deep. The host offers one request at a time, with an address, a write flag, a byte mask and write data. The sequencer turns each request into a cycle-exact pattern of lane chip enables, lane write enables, a shared output enable and a data-bus drive enable. The speed-grade timing (address setup ahead of the strobes, minimum write pulse, data setup ahead of the end of write, read access time and bus release after a read) becomes whole clock-cycle phase lengths, set through parameters.

A write first spends a setup phase with the address and data on the pins and every strobe idle. It then pulls chip enable and write enable low together, only on the lanes named by the mask, for the pulse length. A recovery phase follows, in which the data is still driven. A read gets the same setup phase. It then enables all lanes with output enable low for the access count plus one capture cycle, returns the whole word with a one-cycle valid pulse, and floats the bus for a turnaround phase before the next request can start. The array needs no refresh, so the strobes stay idle between requests.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held, and just after it, req_ready is 1, all lane chip enables and write enables are 1 (inactive), mem_oe_n is 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 for exactly SETUP_CYC+PULSE_CYC+RECOV_CYC cycles after a write, and for SETUP_CYC+ACCESS_CYC+1+TURN_CYC cycles after a read.
- R3: mem_addr equals the accepted address for the whole busy period. During the first SETUP_CYC busy cycles, no chip enable, write enable or output enable is active.
- R4: In a write, each lane whose mask bit is 1 has its chip enable and write enable low together for exactly PULSE_CYC consecutive cycles. Lanes whose mask bit is 0 never see their chip enable or write enable go low.
- R5: mem_oe_n stays 1 for the whole of a write. mem_dq_oe is never 1 while mem_oe_n is 0.
- R6: In a write, mem_dq_oe is 1 from the first setup cycle through the last recovery cycle, and mem_dq_out equals the accepted write data all that time. Lane l uses bits 8l+7 down to 8l.
- R7: In a read, all four lane chip enables and mem_oe_n are 0 and all write enables are 1 for ACCESS_CYC+1 cycles. rsp_valid is 1 for exactly one cycle, the (SETUP_CYC+ACCESS_CYC+2)th cycle after acceptance. In that cycle rsp_rdata carries the bus word sampled at the end of the capture cycle.
- R8: After each read, for TURN_CYC cycles before req_ready returns, mem_oe_n is 1, mem_dq_oe is 0 and every chip enable is 1.
- R9: A write with mask 0 runs a full write-length cycle but strobes no lane, so the stored word is unchanged.
- R10: While req_ready is 1, no chip enable or write enable is active and mem_oe_n is 1. The controller never starts a cycle of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 19 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mask | input | 4 | Byte-lane select for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 32 | Read word |
| mem_addr | output | 19 | Array address |
| mem_ce_n | output | 4 | Per-lane chip enable, active low |
| mem_we_n | output | 4 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 32 | Data driven toward the array |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 32 | Data received from the array |

## Verification
Random sequences mix reads and writes with random masks over a small address window. Read-back values against a reference image show whether masked lanes were written and whether the others were left alone. Directed cases target specific faults. Full-mask and empty-mask writes separate a lane decode error from a missing strobe. A write and a read at the top address expose a truncated address path. A read followed at once by a write shows whether the turnaround phase and the write-time output-enable rule keep the bus free of contention. Each transaction is also timed: the busy length, the length of each lane's write pulse and the cycle of the read pulse tell a wrong phase count apart from wrong decoding.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_SETUP   = 3'd1,
      PH_WPULSE  = 3'd2,
      PH_WRECOV  = 3'd3,
      PH_RACCESS = 3'd4,
      PH_RCAPT   = 3'd5,
      PH_TURN    = 3'd6
   } phase_t;

   function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int unsigned SETUP_CYC  = 1,
   parameter int unsigned PULSE_CYC  = 2,
   parameter int unsigned RECOV_CYC  = 1,
   parameter int unsigned ACCESS_CYC = 2,
   parameter int unsigned TURN_CYC   = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   op_we,
   output phase_t phase
);

   localparam int unsigned MAX_CYC = max_of2(max_of2(max_of2(SETUP_CYC, PULSE_CYC),
                                                     max_of2(RECOV_CYC, ACCESS_CYC)), TURN_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   phase_t           nxt;
   logic [CNT_W-1:0] cnt;
   logic             done;

   function automatic logic [CNT_W-1:0] len_of(input phase_t p);
      case (p)
         PH_SETUP:   return CNT_W'(SETUP_CYC - 1);
         PH_WPULSE:  return CNT_W'(PULSE_CYC - 1);
         PH_WRECOV:  return CNT_W'(RECOV_CYC - 1);
         PH_RACCESS: return CNT_W'(ACCESS_CYC - 1);
         PH_TURN:    return CNT_W'(TURN_CYC - 1);
         default:    return '0;
      endcase
   endfunction

   assign done = (cnt == '0);

   always_comb begin
      nxt = phase;
      case (phase)
         PH_IDLE:    if (start) nxt = PH_SETUP;
         PH_SETUP:   if (done)  nxt = op_we ? PH_WPULSE : PH_RACCESS;
         PH_WPULSE:  if (done)  nxt = PH_WRECOV;
         PH_WRECOV:  if (done)  nxt = PH_IDLE;
         PH_RACCESS: if (done)  nxt = PH_RCAPT;
         PH_RCAPT:              nxt = PH_TURN;
         PH_TURN:    if (done)  nxt = PH_IDLE;
         default:               nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         phase <= nxt;
         if (nxt != phase)  cnt <= len_of(nxt);
         else if (!done)    cnt <= cnt - 1'b1;
      end
   end

   AST_START_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && phase == PH_IDLE) |=> phase == PH_SETUP); // R2
   AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(phase) && phase == PH_WPULSE |-> $past(phase) == PH_SETUP); // R3
   AST_TURN_AFTER_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_RCAPT |=> phase == PH_TURN); // R8

endmodule

// File: rtl/sram_lane_drv.sv
module sram_lane_drv
   import sram_seq_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_t phase,
   input  logic   lane_sel,
   output logic   ce_n,
   output logic   we_n
);

   localparam int unsigned LW = $clog2(PULSE_CYC + 2);

   logic          wr_act;
   logic          rd_act;
   logic [LW-1:0] low_cnt;

   assign wr_act = (phase == PH_WPULSE) && lane_sel;
   assign rd_act = (phase == PH_RACCESS) || (phase == PH_RCAPT);
   assign ce_n   = !(wr_act || rd_act);
   assign we_n   = !wr_act;

   // checker counter: length of the current write-enable low run
   always_ff @(posedge clk) begin
      if (!rst_n)     low_cnt <= '0;
      else if (!we_n) low_cnt <= low_cnt + 1'b1;
      else            low_cnt <= '0;
   end

   AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> low_cnt == LW'(PULSE_CYC)); // R4
   AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> low_cnt < LW'(PULSE_CYC)); // R4
   AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n); // R4

endmodule

// File: rtl/sram_req_regs.sv
module sram_req_regs #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic [LANES-1:0]  req_mask,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] op_addr,
   output logic              op_we,
   output logic [LANES-1:0]  op_mask,
   output logic [DATA_W-1:0] op_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_addr  <= '0;
         op_we    <= 1'b0;
         op_mask  <= '0;
         op_wdata <= '0;
      end else if (accept) begin
         op_addr  <= req_addr;
         op_we    <= req_we;
         op_mask  <= req_mask;
         op_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_in;
      end
   end

   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7
   AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(op_addr) && $stable(op_wdata) && $stable(op_mask)); // R3

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 19,
   parameter int unsigned LANES      = 4,
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned SETUP_CYC  = 1,
   parameter int unsigned PULSE_CYC  = 2,
   parameter int unsigned RECOV_CYC  = 1,
   parameter int unsigned ACCESS_CYC = 2,
   parameter int unsigned TURN_CYC   = 1,
   localparam int unsigned DATA_W    = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic [LANES-1:0]  req_mask,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_ce_n,
   output logic [LANES-1:0]  mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   generate
      if (SETUP_CYC < 1 || PULSE_CYC < 1 || RECOV_CYC < 1 || ACCESS_CYC < 1 || TURN_CYC < 1) begin : g_bad_phase
         $error("sram_seq_ctrl: every phase length must be at least one cycle");
      end
      if (LANES < 1 || LANE_W < 1 || ADDR_W < 1) begin : g_bad_shape
         $error("sram_seq_ctrl: lane count, lane width and address width must be nonzero");
      end
   endgenerate

   phase_t            phase;
   logic              accept;
   logic              op_we;
   logic [LANES-1:0]  op_mask;
   logic [DATA_W-1:0] op_wdata;
   logic              capture;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign capture   = (phase == PH_RCAPT);

   sram_req_regs #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_we    (req_we),
      .req_mask  (req_mask),
      .req_wdata (req_wdata),
      .capture   (capture),
      .mem_dq_in (mem_dq_in),
      .op_addr   (mem_addr),
      .op_we     (op_we),
      .op_mask   (op_mask),
      .op_wdata  (op_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   sram_seq_fsm #(
      .SETUP_CYC  (SETUP_CYC),
      .PULSE_CYC  (PULSE_CYC),
      .RECOV_CYC  (RECOV_CYC),
      .ACCESS_CYC (ACCESS_CYC),
      .TURN_CYC   (TURN_CYC)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .op_we (op_we),
      .phase (phase)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sram_lane_drv #(
         .PULSE_CYC (PULSE_CYC)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .phase    (phase),
         .lane_sel (op_mask[l]),
         .ce_n     (mem_ce_n[l]),
         .we_n     (mem_we_n[l])
      );
   end

   assign mem_oe_n   = !((phase == PH_RACCESS) || (phase == PH_RCAPT));
   assign mem_dq_oe  = (phase == PH_WPULSE) || (phase == PH_WRECOV) ||
                       ((phase == PH_SETUP) && op_we);
   assign mem_dq_out = op_wdata;

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R5
   AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n != '1) |-> mem_oe_n && mem_dq_oe); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n == '1) && (mem_we_n == '1) && mem_oe_n); // R10
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R3
   AST_TURN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TURN) |-> !mem_dq_oe && mem_oe_n && (mem_ce_n == '1)); // R8
   AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n) && mem_oe_n); // R7

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

   localparam int S = 1, P = 2, RC = 1, A = 2, T = 1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [18:0] req_addr;
   logic        req_we;
   logic [3:0]  req_mask;
   logic [31:0] req_wdata;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [18:0] mem_addr;
   logic [3:0]  mem_ce_n;
   logic [3:0]  mem_we_n;
   logic        mem_oe_n;
   logic [31:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [31:0] mem_dq_in;

   int checks = 0;
   int errors = 0;
   int conflicts = 0;
   int idle_bad = 0;

   logic [31:0] arr [256];
   logic [31:0] exp_mem [256];

   always #4 clk = ~clk;

   sram_seq_ctrl u_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_we(req_we), .req_mask(req_mask), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // array model: reads when all lanes enabled with output enable low
   assign mem_dq_in = ((mem_ce_n == 4'b0000) && !mem_oe_n && (mem_we_n == 4'hF))
                      ? arr[mem_addr[7:0]] : 32'hDEAD_BEEF;

   always @(posedge clk) begin
      for (int l = 0; l < 4; l++)
         if (!mem_ce_n[l] && !mem_we_n[l] && mem_dq_oe)
            arr[mem_addr[7:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
   end

   always @(negedge clk) begin
      if (rst_n && mem_dq_oe && !mem_oe_n) conflicts++;
      if (rst_n && req_ready && ((mem_ce_n != 4'hF) || (mem_we_n != 4'hF) || !mem_oe_n)) idle_bad++;
   end

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] m);
      logic [31:0] r = old;
      for (int l = 0; l < 4; l++) if (m[l]) r[l*8 +: 8] = d[l*8 +: 8];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic we, input logic [18:0] a, input logic [3:0] m, input logic [31:0] d);
      int busy = -1, rsp_at = -1, oe_low = 0, addr_bad = 0, data_bad = 0, setup_bad = 0, drv = 0;
      int we_low [4];
      int ce_low [4];
      logic [31:0] got = '0;
      for (int l = 0; l < 4; l++) begin we_low[l] = 0; ce_low[l] = 0; end
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_mask = m; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_wdata = ~d; req_addr = ~a;
      for (int k = 1; k <= 20; k++) begin
         if (req_ready) begin busy = k - 1; break; end
         if (mem_addr != a) addr_bad++;
         if (k <= S && ((mem_ce_n != 4'hF) || (mem_we_n != 4'hF) || !mem_oe_n)) setup_bad++;
         if (!mem_oe_n) oe_low++;
         if (mem_dq_oe) begin drv++; if (mem_dq_out != d) data_bad++; end
         for (int l = 0; l < 4; l++) begin
            if (!mem_we_n[l]) we_low[l]++;
            if (!mem_ce_n[l]) ce_low[l]++;
         end
         if (rsp_valid) begin rsp_at = k; got = rsp_rdata; end
         @(negedge clk);
      end
      chk(addr_bad == 0, "R3 address held", 32'(addr_bad), 0);
      chk(setup_bad == 0, "R3 setup quiet", 32'(setup_bad), 0);
      if (we) begin
         chk(busy == S + P + RC, "R2 write busy length", 32'(busy), 32'(S + P + RC));
         chk(oe_low == 0, "R5 oe high during write", 32'(oe_low), 0);
         chk(drv == S + P + RC && data_bad == 0, "R6 write data driven",
             32'(drv), 32'(S + P + RC));
         for (int l = 0; l < 4; l++) begin
            chk(we_low[l] == (m[l] ? P : 0) && ce_low[l] == we_low[l],
                m == 4'h0 ? "R9 empty mask strobes" : "R4 lane pulse",
                32'(we_low[l]), 32'(m[l] ? P : 0));
         end
         exp_mem[a[7:0]] = merge(exp_mem[a[7:0]], d, m);
      end else begin
         chk(busy == S + A + 1 + T, "R2 read busy length", 32'(busy), 32'(S + A + 1 + T));
         chk(oe_low == A + 1 && ce_low[0] == A + 1 && ce_low[3] == A + 1 && we_low[2] == 0,
             "R7 read strobes", 32'(oe_low), 32'(A + 1));
         chk(rsp_at == S + A + 2, "R7 rsp timing", 32'(rsp_at), 32'(S + A + 2));
         chk(got == exp_mem[a[7:0]], "R7 read data", got, exp_mem[a[7:0]]);
         chk(drv == 0, "R8 bus floated on read", 32'(drv), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      for (int i = 0; i < 256; i++) begin arr[i] = '0; exp_mem[i] = '0; end
      rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_mask = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      chk(req_ready && mem_ce_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe && !rsp_valid,
          "R1 reset state", {mem_ce_n, mem_we_n}, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_ce_n == 4'hF && !mem_dq_oe, "R1 after reset", {31'd0, req_ready}, 1);

      // directed corners
      do_op(1'b1, 19'h00010, 4'hF, 32'h1122_3344);
      do_op(1'b0, 19'h00010, 4'h0, 32'h0);
      do_op(1'b1, 19'h00010, 4'h0, 32'hFFFF_FFFF);  // R9 mask zero
      do_op(1'b0, 19'h00010, 4'h0, 32'h0);
      do_op(1'b1, 19'h7FFFF, 4'b0101, 32'hA5A5_5A5A);
      do_op(1'b0, 19'h7FFFF, 4'h0, 32'h0);
      do_op(1'b0, 19'h00010, 4'h0, 32'h0);
      do_op(1'b1, 19'h00010, 4'b1000, 32'h7700_0000); // write right after read (R8)
      do_op(1'b0, 19'h00010, 4'h0, 32'h0);

      for (int i = 0; i < 80; i++) begin
         do_op(1'($urandom_range(0, 1)), 19'($urandom_range(0, 15)),
               4'($urandom_range(0, 15)), $urandom());
      end

      repeat (4) @(negedge clk);
      chk(conflicts == 0, "R5 no bus contention", 32'(conflicts), 0);
      chk(idle_bad == 0, "R10 idle strobes quiet", 32'(idle_bad), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule